// File: doc/BRIEF.md
# Banked GPIO and Pin-Mux Controller

This block owns a row of general-purpose pads and decides, pin by pin, who drives each one: the software-visible GPIO registers, an alternate on-chip function, or a UART overlay that claims a fixed group of four pins. Software reaches the block through a simple single-cycle register bus. Direction and data state are kept in 32-bit banks. The bank that holds the higher pin numbers sits four bytes *below* the bank that holds the lower pin numbers.

Every pad input passes through a two-flop synchronizer. The synchronized value feeds three things: data register readback, the alternate-function sense lines and the UART receive lines. Each pin uses a fixed priority. The overlay comes first, then the per-pin alternate-function select, then plain GPIO. A pin that is not enabled as an output drives a low value.

Top module: `pmx_gpio_top`

## Requirements
- R1: After reset every register reads zero, every pad has output enable 0 and output value 0, and the UART receive lines sit at 1.
- R2: Pin n lives in bit (n mod 32) of bank (n div 32), and bank k sits at the bank-0 address minus 4·k. The addresses are: direction 0x04 (pins 0-31) and 0x00 (pins 32-37 in bits 5:0); data 0x0C and 0x08; mode 0x18; overlay 0x38, which holds 16 writable bits. Unimplemented bits read 0.
- R3: When a pin is under GPIO control, a direction bit of 1 makes it an output that drives its data latch bit, and a direction bit of 0 makes it an input.
- R4: For pins 0-31, a mode bit of 1 routes the pin to its alternate function. The pad then drives func_drive, and the output enable is fixed per pin: outputs for pins 0-14 and 26-31, inputs for pins 15-25. The GPIO direction bit is ignored.
- R5: Pins 32-37 have no mode bit. Writes to the would-be upper mode address 0x14 change no pad, and that address reads 0.
- R6: When overlay bits 2:0 equal 1, pins 30-33 are taken by the UART, ahead of mode and GPIO. Pin 31 drives uart_to_pad[0] and pin 32 drives uart_to_pad[1]. Pins 30 and 33 are inputs whose synchronized values appear on uart_from_pad[0] and uart_from_pad[1]. Any other value in bits 2:0 means no overlay, and then uart_from_pad reads 2'b11.
- R7: A data register read returns the output latch for pins whose direction bit is 1, and the synchronized pad input for pins whose direction bit is 0. Writes change only the latch.
- R8: Pad inputs reach readback, func_sense and uart_from_pad through two flops. After a pad change between edges, reads captured at the next two edges still return the old value, and the third edge returns the new one.
- R9: A write captured at a clock edge is visible on the pads right after that edge. bus_rdata updates at the edge that captures a read and holds otherwise. Unmapped addresses read 0.
- R10: pad_out is 0 on every pin whose pad_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 38 | Pad input values |
| pad_out | output | 38 | Pad output values |
| pad_oe | output | 38 | Pad output enables |
| func_drive | input | 32 | Alternate-function output values for pins 0-31 |
| func_sense | output | 32 | Synchronized pad inputs for pins 0-31 |
| uart_to_pad | input | 2 | UART outputs for pins 31 and 32 |
| uart_from_pad | output | 2 | UART inputs from pins 30 and 33 |

## Verification
The bench builds the block with its default parameters: 38 pins, 32-bit banks, an 8-bit address, a 16-bit overlay field and the UART group based at pin 30. With these values the upper bank is only partly filled, so its unimplemented bits become observable. The overlay group also straddles the bank boundary, so one overlay setting has to override mode bits in bank 0 and plain GPIO in bank 1 at the same time. Random register traffic mixes overlay values that do and do not select the UART, and directed cases cover the synchronizer latency and the reversed bank addressing.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      OVL_NONE = 3'd0,
      OVL_UART = 3'd1
   } ovl_sel_e;

   // byte address of bank k of a register whose bank-0 copy is at base
   function automatic int bank_addr(int base, int bank);
      return base - 4 * bank;
   endfunction
endpackage

// File: rtl/pmx_sync.sv
module pmx_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/pmx_regs.sv
module pmx_regs
   import pmx_pkg::*;
#(
   parameter int NUM_PINS  = 38,
   parameter int BANK_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int DIR_BASE  = 'h04,
   parameter int DATA_BASE = 'h0C,
   parameter int MODE_ADDR = 'h18,
   parameter int OVL_ADDR  = 'h38,
   parameter int OVL_W     = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_en,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BANK_W-1:0]   bus_wdata,
   output logic [BANK_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_sync,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] dat_q,
   output logic [BANK_W-1:0]   mode_q,
   output logic [SEL_W-1:0]    ovl_sel
);
   localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
   localparam logic [ADDR_W-1:0] OVL_A  = ADDR_W'(OVL_ADDR);

   logic [OVL_W-1:0]  ovl_q;
   logic [BANK_W-1:0] rd_mux;
   logic              wr_hit;

   assign wr_hit  = bus_en && bus_we;
   assign ovl_sel = ovl_q[SEL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q     <= '0;
         dat_q     <= '0;
         mode_q    <= '0;
         ovl_q     <= '0;
         bus_rdata <= '0;
      end else begin
         if (wr_hit) begin
            for (int p = 0; p < NUM_PINS; p++) begin
               if (bus_addr == ADDR_W'(bank_addr(DIR_BASE, p / BANK_W)))
                  dir_q[p] <= bus_wdata[p % BANK_W];
               if (bus_addr == ADDR_W'(bank_addr(DATA_BASE, p / BANK_W)))
                  dat_q[p] <= bus_wdata[p % BANK_W];
            end
            if (bus_addr == MODE_A) mode_q <= bus_wdata;
            if (bus_addr == OVL_A)  ovl_q  <= bus_wdata[OVL_W-1:0];
         end
         if (bus_en && !bus_we) bus_rdata <= rd_mux;
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (bus_addr == ADDR_W'(bank_addr(DIR_BASE, p / BANK_W)))
            rd_mux[p % BANK_W] = dir_q[p];
         if (bus_addr == ADDR_W'(bank_addr(DATA_BASE, p / BANK_W)))
            rd_mux[p % BANK_W] = dir_q[p] ? dat_q[p] : pin_sync[p];
      end
      if (bus_addr == MODE_A) rd_mux = mode_q;
      if (bus_addr == OVL_A)  rd_mux = {{(BANK_W-OVL_W){1'b0}}, ovl_q};
   end
endmodule

// File: rtl/pmx_pin_mux.sv
module pmx_pin_mux #(
   parameter bit HAS_MODE   = 1'b1,
   parameter bit ALT_IS_OUT = 1'b0,
   parameter bit IN_GRP     = 1'b0,
   parameter bit GRP_OUT    = 1'b0
) (
   input  logic gpio_dir,
   input  logic gpio_dat,
   input  logic alt_en,
   input  logic alt_val,
   input  logic ovl_on,
   input  logic ovl_val,
   output logic pad_out,
   output logic pad_oe
);
   logic take_ovl, take_alt, drv;

   assign take_ovl = IN_GRP && ovl_on;
   assign take_alt = HAS_MODE && alt_en;

   always_comb begin
      if (take_ovl) begin
         pad_oe = GRP_OUT;
         drv    = ovl_val;
      end else if (take_alt) begin
         pad_oe = ALT_IS_OUT;
         drv    = alt_val;
      end else begin
         pad_oe = gpio_dir;
         drv    = gpio_dat;
      end
   end

   assign pad_out = pad_oe & drv;
endmodule

// File: rtl/pmx_gpio_top.sv
module pmx_gpio_top
   import pmx_pkg::*;
#(
   parameter int          NUM_PINS     = 38,
   parameter int          BANK_W       = 32,
   parameter int          ADDR_W       = 8,
   parameter int          DIR_BASE     = 'h04,
   parameter int          DATA_BASE    = 'h0C,
   parameter int          MODE_ADDR    = 'h18,
   parameter int          OVL_ADDR     = 'h38,
   parameter int          OVL_W        = 16,
   parameter int          UART_BASE    = 30,
   parameter logic [31:0] ALT_OUT_MASK = 32'hFC00_7FFF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_en,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BANK_W-1:0]   bus_wdata,
   output logic [BANK_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   input  logic [BANK_W-1:0]   func_drive,
   output logic [BANK_W-1:0]   func_sense,
   input  logic [1:0]          uart_to_pad,
   output logic [1:0]          uart_from_pad
);
   localparam int NBANK = (NUM_PINS + BANK_W - 1) / BANK_W;
   localparam logic [NUM_PINS-1:0] ALT_OUT_X = NUM_PINS'(ALT_OUT_MASK);

   if (NUM_PINS < BANK_W || NBANK > 2) begin : g_bad_pins
      $error("pin count must fill one bank and fit in two");
   end
   if (DIR_BASE < 4 * (NBANK - 1) || DATA_BASE < 4 * (NBANK - 1)) begin : g_bad_base
      $error("bank-0 base too low for reversed bank layout");
   end
   if (OVL_W < SEL_W || OVL_W > BANK_W || BANK_W > 32) begin : g_bad_ovl
      $error("overlay width out of range");
   end
   if (UART_BASE + 3 >= NUM_PINS) begin : g_bad_uart
      $error("UART group exceeds pin count");
   end

   logic [NUM_PINS-1:0] pin_sync, dir_q, dat_q, mode_x, drive_x;
   logic [BANK_W-1:0]   mode_q;
   logic [SEL_W-1:0]    ovl_sel;
   logic                ovl_on;

   pmx_sync #(.W(NUM_PINS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
   );

   pmx_regs #(
      .NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
      .DIR_BASE(DIR_BASE), .DATA_BASE(DATA_BASE), .MODE_ADDR(MODE_ADDR),
      .OVL_ADDR(OVL_ADDR), .OVL_W(OVL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_sync(pin_sync), .dir_q(dir_q), .dat_q(dat_q),
      .mode_q(mode_q), .ovl_sel(ovl_sel)
   );

   assign ovl_on  = (ovl_sel == OVL_UART);
   assign mode_x  = NUM_PINS'(mode_q);
   assign drive_x = NUM_PINS'(func_drive);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int OFS = p - UART_BASE;
      logic ovl_val;

      if (OFS == 1) begin : g_tx0
         assign ovl_val = uart_to_pad[0];
      end else if (OFS == 2) begin : g_tx1
         assign ovl_val = uart_to_pad[1];
      end else begin : g_notx
         assign ovl_val = 1'b0;
      end

      pmx_pin_mux #(
         .HAS_MODE  (p < BANK_W),
         .ALT_IS_OUT(ALT_OUT_X[p]),
         .IN_GRP    (OFS >= 0 && OFS < 4),
         .GRP_OUT   (OFS == 1 || OFS == 2)
      ) u_mux (
         .gpio_dir(dir_q[p]), .gpio_dat(dat_q[p]),
         .alt_en(mode_x[p]), .alt_val(drive_x[p]),
         .ovl_on(ovl_on), .ovl_val(ovl_val),
         .pad_out(pad_out[p]), .pad_oe(pad_oe[p])
      );
   end

   assign func_sense    = pin_sync[BANK_W-1:0];
   assign uart_from_pad = ovl_on ? {pin_sync[UART_BASE+3], pin_sync[UART_BASE]} : 2'b11;
endmodule

// File: rtl/pmx_gpio_checker.sv
module pmx_gpio_checker #(
   parameter int NUM_PINS  = 38,
   parameter int BANK_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int UART_BASE = 30
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_en,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [BANK_W-1:0]   bus_wdata,
   input logic [BANK_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [BANK_W-1:0]   func_drive,
   input logic [1:0]          uart_to_pad,
   input logic [NUM_PINS-1:0] dir_q,
   input logic [BANK_W-1:0]   mode_q,
   input logic [2:0]          ovl_sel
);
   a_r10_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   a_r6_uart_dirs: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl_sel == 3'd1) |-> (pad_oe[UART_BASE+1] && pad_oe[UART_BASE+2]
                             && !pad_oe[UART_BASE] && !pad_oe[UART_BASE+3]));

   a_r6_uart_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl_sel == 3'd1) |-> (pad_out[UART_BASE+1] == uart_to_pad[0]
                             && pad_out[UART_BASE+2] == uart_to_pad[1]));

   a_r5_upper_gpio: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[NUM_PINS-1:UART_BASE+4] == dir_q[NUM_PINS-1:UART_BASE+4]);

   a_r4_alt_input: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[20] |-> !pad_oe[20]);

   a_r4_alt_output: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[0] |-> (pad_oe[0] && pad_out[0] == func_drive[0]));

   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_addr == ADDR_W'('h40)) |=> (bus_rdata == '0));

   a_r2_ovl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_addr == ADDR_W'('h38)) |=> (ovl_sel == $past(bus_wdata[2:0])));
endmodule

bind pmx_gpio_top pmx_gpio_checker #(
   .NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .UART_BASE(UART_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pad_out(pad_out), .pad_oe(pad_oe), .func_drive(func_drive),
   .uart_to_pad(uart_to_pad), .dir_q(dir_q), .mode_q(mode_q), .ovl_sel(ovl_sel)
);

// File: tb/test_pmx_gpio_top.sv
`timescale 1ns/1ps
module test_pmx_gpio_top;
   localparam logic [31:0] ALT_OUT = 32'hFC00_7FFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [37:0] pad_in = '0, pad_out, pad_oe;
   logic [31:0] func_drive = '0, func_sense;
   logic [1:0]  uart_to_pad = '0, uart_from_pad;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [37:0] m_dir = '0, m_dat = '0;
   logic [31:0] m_mode = '0;
   logic [15:0] m_ovl = '0;

   always #4 clk = ~clk;

   pmx_gpio_top i_pmx_gpio_top (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .func_drive(func_drive), .func_sense(func_sense),
      .uart_to_pad(uart_to_pad), .uart_from_pad(uart_from_pad)
   );

   function automatic bit ovl_uart();
      return m_ovl[2:0] == 3'd1;
   endfunction

   function automatic logic [37:0] exp_oe();
      logic [37:0] v;
      for (int p = 0; p < 38; p++) begin
         if (ovl_uart() && p >= 30 && p <= 33) v[p] = (p == 31 || p == 32);
         else if (p < 32 && m_mode[p])         v[p] = ALT_OUT[p];
         else                                  v[p] = m_dir[p];
      end
      return v;
   endfunction

   function automatic logic [37:0] exp_out();
      logic [37:0] oe = exp_oe();
      logic [37:0] v;
      for (int p = 0; p < 38; p++) begin
         if (ovl_uart() && p >= 30 && p <= 33) v[p] = (p == 31) ? uart_to_pad[0] : uart_to_pad[1];
         else if (p < 32 && m_mode[p])         v[p] = func_drive[p];
         else                                  v[p] = m_dat[p];
         v[p] = v[p] & oe[p];
      end
      return v;
   endfunction

   function automatic logic [31:0] exp_rd(logic [7:0] a);
      logic [31:0] v = '0;
      case (a)
         8'h04: v = m_dir[31:0];
         8'h00: v = {26'd0, m_dir[37:32]};
         8'h0C: for (int p = 0; p < 32; p++) v[p] = m_dir[p] ? m_dat[p] : pad_in[p];
         8'h08: for (int p = 32; p < 38; p++) v[p-32] = m_dir[p] ? m_dat[p] : pad_in[p];
         8'h18: v = m_mode;
         8'h38: v = {16'd0, m_ovl};
         default: v = '0;
      endcase
      return v;
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_write(logic [7:0] a, logic [31:0] d);
      case (a)
         8'h04: m_dir[31:0]  = d;
         8'h00: m_dir[37:32] = d[5:0];
         8'h0C: m_dat[31:0]  = d;
         8'h08: m_dat[37:32] = d[5:0];
         8'h18: m_mode       = d;
         8'h38: m_ovl        = d[15:0];
         default: ;
      endcase
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 0; bus_we = 0;
      model_write(a, d);
   endtask

   task automatic bus_read(logic [7:0] a, output logic [31:0] r);
      @(negedge clk);
      bus_en = 1; bus_we = 0; bus_addr = a;
      @(negedge clk);
      bus_en = 0;
      r = bus_rdata;
   endtask

   task automatic read_check(string tag, logic [7:0] a);
      logic [31:0] r;
      bus_read(a, r);
      check(tag, 64'(r), 64'(exp_rd(a)));
   endtask

   task automatic check_pads(string tag);
      check(tag, 64'(pad_oe), 64'(exp_oe()));
      check(tag, 64'(pad_out), 64'(exp_out()));
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check("R1 reset oe", 64'(pad_oe), 64'd0);
      check("R1 reset out", 64'(pad_out), 64'd0);
      check("R1 reset uart rx idle", 64'(uart_from_pad), 64'd3);
      rst_n = 1;
      read_check("R1 reset dir", 8'h04);
      read_check("R1 reset ovl", 8'h38);

      // R2 reversed banks, partial upper bank
      bus_write(8'h00, 32'hFFFF_FFC5);
      read_check("R2 upper dir bank", 8'h00);
      bus_write(8'h08, 32'h0000_003F);
      check_pads("R3 R9 upper pins gpio after one edge");
      read_check("R2 upper data bank", 8'h08);

      // R5 no mode bits for upper pins
      bus_write(8'h14, 32'hFFFF_FFFF);
      check_pads("R5 upper mode write ignored");
      read_check("R5 upper mode reads zero", 8'h14);

      // R4 alternate functions override direction
      bus_write(8'h04, 32'h0010_0001);
      bus_write(8'h0C, 32'h0000_0000);
      func_drive = 32'h0000_0001;
      bus_write(8'h18, 32'h0010_0001);
      check_pads("R4 alt out pin0 alt in pin20");

      // R6 overlay with upper bits set still selects UART
      uart_to_pad = 2'b10;
      pad_in[30] = 1'b1; pad_in[33] = 1'b0;
      bus_write(8'h18, 32'hC010_0001);
      bus_write(8'h00, 32'h0000_0003);
      bus_write(8'h38, 32'h0000_0009);
      settle();
      check_pads("R6 overlay takes group");
      check("R6 uart rx", 64'(uart_from_pad), 64'b01);
      bus_write(8'h38, 32'h0000_0002);
      check_pads("R6 overlay value 2 is gpio");
      check("R6 uart rx idle", 64'(uart_from_pad), 64'b11);

      // R7 readback per direction
      bus_write(8'h04, 32'h0000_0020);
      bus_write(8'h0C, 32'h0000_0060);
      pad_in[6:5] = 2'b00;
      settle();
      read_check("R7 out latch vs pad input", 8'h0C);
      bus_write(8'h04, 32'h0000_0060);
      read_check("R7 latch revealed after dir change", 8'h0C);

      // R8 two-flop latency
      bus_write(8'h04, 32'h0);
      pad_in[3] = 1'b0;
      settle();
      @(negedge clk);
      pad_in[3] = 1'b1; bus_en = 1; bus_we = 0; bus_addr = 8'h0C;
      @(negedge clk); check("R8 edge1 old", 64'(bus_rdata[3]), 64'd0);
      @(negedge clk); check("R8 edge2 old", 64'(bus_rdata[3]), 64'd0);
      @(negedge clk); check("R8 edge3 new", 64'(bus_rdata[3]), 64'd1);
      bus_en = 0;

      // R9 unmapped
      read_check("R9 unmapped 0x3C", 8'h3C);
      read_check("R9 unmapped 0x40", 8'h40);

      // random traffic
      for (int it = 0; it < 400; it++) begin
         logic [7:0]  a;
         logic [31:0] d;
         pad_in      = {$urandom, $urandom} & 38'h3F_FFFF_FFFF;
         func_drive  = $urandom;
         uart_to_pad = 2'($urandom);
         settle();
         case ($urandom % 9)
            0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
            4: a = 8'h14; 5: a = 8'h18; 6: a = 8'h38; 7: a = 8'h3C;
            default: a = 8'($urandom);
         endcase
         d = $urandom;
         if (a == 8'h38 && ($urandom % 2 == 0)) d = (d & 32'hFFF8) | 32'h1;
         if ($urandom % 3 == 0) read_check("R2 R7 R9 random read", a);
         else begin
            bus_write(a, d);
            read_check("R2 R7 random readback", a);
         end
         check_pads("R3 R4 R6 R10 random pads");
         check("R8 func sense", 64'(func_sense), 64'(pad_in[31:0]));
         check("R6 random uart rx", 64'(uart_from_pad),
               ovl_uart() ? 64'({pad_in[33], pad_in[30]}) : 64'd3);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule